// File: doc/BRIEF.md
# Three-Phase Gate Sequencer with Dead Time and Latched Shutdown

The block turns six host PWM lines into six gate commands for three half-bridges. For each phase it works out which switch, high or low, should conduct. A newly requested switch is switched on only after a programmable dead time. The switch that is leaving is switched off at once. The result is that the two switches of one phase never conduct together, and the gap between them is the same in both switching directions.

Two input styles are accepted. In the normal style each switch has its own input, and a phase that asks for both switches gets neither. When all three high-side inputs sit high at once, the block changes to a three-line style. In that style each low-side input alone sets its phase complementarily, and the block supplies the dead times itself.

Every gate is held off while the enable input is low. Gates are also held off while a protection trip is active or latched. A supply overvoltage always trips the block. A drain-source fault trips it only when the configuration allows it. A regulator overvoltage trips it only when the configuration allows it. A latched trip clears only when the host acknowledges the end of the fault frame and no trip source is active.

Top module: `hb_deadtime_gate`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, all six gate outputs are 0.
- R2: In six-line style (hi_pwm not 3'b111), a phase drives its high gate when only hi_pwm is 1, drives its low gate when only lo_pwm is 1, and drives neither gate when both inputs are 0.
- R3: In six-line style, a phase whose hi_pwm and lo_pwm are both 1 has both gates 0 from the next cycle onward.
- R4: When hi_pwm is 3'b111, a phase drives its low gate when its lo_pwm is 1 and drives its high gate when its lo_pwm is 0.
- R5: The dead-time code sets the delay: 0→0, 1→2, 2→3, 3→4, 4→6, 5→8, 6→12 and 7→24 quarter-steps, each quarter-step being CYC_PER_QUARTER clock cycles (0, 4, 6, 8, 12, 16, 24 or 48 cycles with the default value of 2). Suppose the requested switch of a phase changes and the clock edge captures the change. From that edge, the old gate is 0. The new gate becomes 1 once D further edges have passed, where D is the delay. The same delay applies in both switching directions.
- R6: When enable is 0, all gates are 0 in the same cycle. When enable returns to 1, the gates follow the sequencer at once.
- R7: When fault_supply_ov is 1, all gates are forced to 0, whatever the configuration bits are.
- R8: fault_vds trips the block only when cfg_vds_cmp_en and cfg_vds_fb_en are both 1. When either bit is 0, the fault has no effect on the gates.
- R9: fault_reg_ov trips the block when cfg_reg_fb_en is 1. When cfg_reg_fb_en is 0, the fault has no effect on the gates.
- R10: A trip turns all gates to 0 in the cycle it is raised, and the trip is latched. The latch clears at the first clock edge where eof_ack is 1 and no trip source is active. An acknowledge that arrives while a source is still active does not clear the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_pwm | input | 3 | High-side PWM request per phase |
| lo_pwm | input | 3 | Low-side PWM request per phase |
| enable | input | 1 | Bridge enable; 0 forces all gates off |
| fault_supply_ov | input | 1 | Supply overvoltage flag (never masked) |
| fault_vds | input | 1 | Drain-source overvoltage flag |
| fault_reg_ov | input | 1 | Gate regulator overvoltage flag |
| cfg_dead_code | input | 3 | Dead-time code |
| cfg_vds_cmp_en | input | 1 | Drain-source comparator enable |
| cfg_vds_fb_en | input | 1 | Drain-source trip enable |
| cfg_reg_fb_en | input | 1 | Regulator overvoltage trip enable |
| eof_ack | input | 1 | Host acknowledge of the end-of-frame code |
| hi_gate | output | 3 | High-side gate command per phase |
| lo_gate | output | 3 | Low-side gate command per phase |

## Verification
If a phase holds a stale requested switch, a gate is wrong within one cycle of the input edge. If a dead-time counter runs fast or slow, the turn-on moves by the counting error, and that shows up within at most 48 cycles of the edge. A latch that fails to set shows up as gates coming back the cycle after a fault pulse ends. A latch that clears on the wrong acknowledge shows up as gates returning while a trip source is still active. Because each gate is compared in every cycle, any of these errors appears at the ports in the first cycle where the model and the design disagree.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_req_t;

    localparam int unsigned DEAD_QUARTERS_MAX = 24;

    function automatic int unsigned dead_quarters(input logic [2:0] code);
        case (code)
            3'd0:    return 0;
            3'd1:    return 2;
            3'd2:    return 3;
            3'd3:    return 4;
            3'd4:    return 6;
            3'd5:    return 8;
            3'd6:    return 12;
            default: return 24;
        endcase
    endfunction

    function automatic phase_req_t resolve_phase(input logic tri_mode,
                                                 input logic hi_in,
                                                 input logic lo_in);
        if (tri_mode)
            return lo_in ? PH_LOW : PH_HIGH;
        else if (hi_in && !lo_in)
            return PH_HIGH;
        else if (lo_in && !hi_in)
            return PH_LOW;
        else
            return PH_OFF;
    endfunction

endpackage

// File: rtl/hbg_request_decode.sv
module hbg_request_decode
    import hbg_pkg::*;
#(
    parameter int NUM_PHASES = 3
) (
    input  logic [NUM_PHASES-1:0]   hi_pwm,
    input  logic [NUM_PHASES-1:0]   lo_pwm,
    output phase_req_t [NUM_PHASES-1:0] req
);
    logic tri_mode;

    assign tri_mode = &hi_pwm;

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
        assign req[p] = resolve_phase(tri_mode, hi_pwm[p], lo_pwm[p]);
    end

endmodule

// File: rtl/hbg_phase_timer.sv
module hbg_phase_timer
    import hbg_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_req_t       req,
    input  logic [CNT_W-1:0] dead,
    input  logic             allow,
    output logic             hi_gate,
    output logic             lo_gate
);
    phase_req_t       held_q;
    logic [CNT_W-1:0] cnt_q;
    logic             settled;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= PH_OFF;
            cnt_q  <= '0;
        end else if (req != held_q) begin
            held_q <= req;
            cnt_q  <= '0;
        end else if (cnt_q < dead) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign settled = (cnt_q >= dead);
    assign hi_gate = allow && settled && (held_q == PH_HIGH);
    assign lo_gate = allow && settled && (held_q == PH_LOW);

    // R5
    hi_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(hi_gate) && dead != '0) |-> !$past(lo_gate));

    // R5
    lo_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(lo_gate) && dead != '0) |-> !$past(hi_gate));

endmodule

// File: rtl/hbg_fault_latch.sv
module hbg_fault_latch (
    input  logic clk,
    input  logic rst,
    input  logic supply_ov,
    input  logic vds,
    input  logic reg_ov,
    input  logic vds_cmp_en,
    input  logic vds_fb_en,
    input  logic reg_fb_en,
    input  logic eof_ack,
    output logic trip,
    output logic blocked
);
    logic latched_q;

    assign trip = supply_ov
                | (vds && vds_cmp_en && vds_fb_en)
                | (reg_ov && reg_fb_en);

    always_ff @(posedge clk) begin
        if (rst)
            latched_q <= 1'b0;
        else if (trip)
            latched_q <= 1'b1;
        else if (eof_ack)
            latched_q <= 1'b0;
    end

    assign blocked = trip | latched_q;

    // R10
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (latched_q && !eof_ack) |=> latched_q);

    // R10
    ack_under_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (eof_ack && trip) |=> blocked);

endmodule

// File: rtl/hb_deadtime_gate.sv
module hb_deadtime_gate
    import hbg_pkg::*;
#(
    parameter int NUM_PHASES      = 3,
    parameter int CYC_PER_QUARTER = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PHASES-1:0] hi_pwm,
    input  logic [NUM_PHASES-1:0] lo_pwm,
    input  logic                  enable,
    input  logic                  fault_supply_ov,
    input  logic                  fault_vds,
    input  logic                  fault_reg_ov,
    input  logic [2:0]            cfg_dead_code,
    input  logic                  cfg_vds_cmp_en,
    input  logic                  cfg_vds_fb_en,
    input  logic                  cfg_reg_fb_en,
    input  logic                  eof_ack,
    output logic [NUM_PHASES-1:0] hi_gate,
    output logic [NUM_PHASES-1:0] lo_gate
);
    localparam int DEAD_MAX = DEAD_QUARTERS_MAX * CYC_PER_QUARTER;
    localparam int CNT_W    = $clog2(DEAD_MAX + 1);

    phase_req_t [NUM_PHASES-1:0] req;
    logic [CNT_W-1:0]            dead_cyc;
    logic                        trip;
    logic                        blocked;
    logic                        allow;

    assign dead_cyc = CNT_W'(dead_quarters(cfg_dead_code) * CYC_PER_QUARTER);
    assign allow    = enable && !blocked;

    hbg_request_decode #(.NUM_PHASES(NUM_PHASES)) u_decode (
        .hi_pwm (hi_pwm),
        .lo_pwm (lo_pwm),
        .req    (req)
    );

    hbg_fault_latch u_fault (
        .clk        (clk),
        .rst        (rst),
        .supply_ov  (fault_supply_ov),
        .vds        (fault_vds),
        .reg_ov     (fault_reg_ov),
        .vds_cmp_en (cfg_vds_cmp_en),
        .vds_fb_en  (cfg_vds_fb_en),
        .reg_fb_en  (cfg_reg_fb_en),
        .eof_ack    (eof_ack),
        .trip       (trip),
        .blocked    (blocked)
    );

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_leg
        hbg_phase_timer #(.CNT_W(CNT_W)) u_timer (
            .clk     (clk),
            .rst     (rst),
            .req     (req[p]),
            .dead    (dead_cyc),
            .allow   (allow),
            .hi_gate (hi_gate[p]),
            .lo_gate (lo_gate[p])
        );

        // R3
        both_req_off_chk: assert property (@(posedge clk) disable iff (rst)
            (!(&hi_pwm) && hi_pwm[p] && lo_pwm[p]) |=> (!hi_gate[p] && !lo_gate[p]));

        // R4
        tri_low_cuts_high_chk: assert property (@(posedge clk) disable iff (rst)
            ((&hi_pwm) && lo_pwm[p]) |=> !hi_gate[p]);
    end

    // R6
    enable_off_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (hi_gate == '0 && lo_gate == '0));

    // R7
    supply_ov_off_chk: assert property (@(posedge clk) disable iff (rst)
        fault_supply_ov |-> (hi_gate == '0 && lo_gate == '0));

    // R10
    trip_latches_chk: assert property (@(posedge clk) disable iff (rst)
        trip |=> (hi_gate == '0 && lo_gate == '0));

endmodule

// File: tb/hb_deadtime_gate_test.sv
module hb_deadtime_gate_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hi_pwm = '0, lo_pwm = '0;
    logic       enable = 1'b0;
    logic       f_sov = 1'b0, f_vds = 1'b0, f_rov = 1'b0;
    logic [2:0] code = 3'd3;
    logic       vcmp = 1'b1, vfb = 1'b1, rfb = 1'b1;
    logic       ack = 1'b0;
    logic [2:0] hi_gate, lo_gate;

    int    total = 0, bad = 0;
    string tag = "R1";
    bit    finished = 1'b0;

    int m_last [3];
    int m_cnt  [3];
    bit m_latch;

    always #(CLK_PERIOD/2) clk = ~clk;

    hb_deadtime_gate uut (
        .clk(clk), .rst(rst), .hi_pwm(hi_pwm), .lo_pwm(lo_pwm),
        .enable(enable), .fault_supply_ov(f_sov), .fault_vds(f_vds),
        .fault_reg_ov(f_rov), .cfg_dead_code(code), .cfg_vds_cmp_en(vcmp),
        .cfg_vds_fb_en(vfb), .cfg_reg_fb_en(rfb), .eof_ack(ack),
        .hi_gate(hi_gate), .lo_gate(lo_gate)
    );

    function automatic int dead_of(input logic [2:0] c);
        int ns;
        case (c)
            3'd0: ns = 0;    3'd1: ns = 500;  3'd2: ns = 750;  3'd3: ns = 1000;
            3'd4: ns = 1500; 3'd5: ns = 2000; 3'd6: ns = 3000; default: ns = 6000;
        endcase
        return ns * Q / 250;
    endfunction

    function automatic bit model_trip();
        return f_sov || (f_vds && vcmp && vfb) || (f_rov && rfb);
    endfunction

    // reference model: 0 = off, 1 = high side wanted, 2 = low side wanted
    always @(posedge clk) begin
        if (rst) begin
            m_latch = 1'b0;
            for (int i = 0; i < 3; i++) begin m_last[i] = 0; m_cnt[i] = 0; end
        end else begin
            int want;
            m_latch = model_trip() || (m_latch && !ack);
            for (int i = 0; i < 3; i++) begin
                if (hi_pwm == 3'b111) want = lo_pwm[i] ? 2 : 1;
                else if (hi_pwm[i] && !lo_pwm[i]) want = 1;
                else if (lo_pwm[i] && !hi_pwm[i]) want = 2;
                else want = 0;
                if (want != m_last[i]) begin m_last[i] = want; m_cnt[i] = 0; end
                else if (m_cnt[i] < dead_of(code)) m_cnt[i]++;
            end
        end
    end

    task automatic compare();
        logic [2:0] eh, el;
        bit off;
        off = !enable || m_latch || model_trip();
        for (int i = 0; i < 3; i++) begin
            eh[i] = !off && m_last[i] == 1 && m_cnt[i] >= dead_of(code);
            el[i] = !off && m_last[i] == 2 && m_cnt[i] >= dead_of(code);
        end
        total += 2;
        if (hi_gate !== eh) begin
            bad++;
            $display("FAIL %s hi_gate actual=%b expected=%b t=%0t", tag, hi_gate, eh, $time);
        end
        if (lo_gate !== el) begin
            bad++;
            $display("FAIL %s lo_gate actual=%b expected=%b t=%0t", tag, lo_gate, el, $time);
        end
    endtask

    task automatic run(input int n);
        #1 compare();
        repeat (n) begin
            @(negedge clk);
            #1 compare();
        end
    endtask

    task automatic ack_pulse();
        ack = 1'b1; run(1);
        ack = 1'b0; run(4);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs low while reset held
        total++;
        if (hi_gate !== 3'b000 || lo_gate !== 3'b000) begin
            bad++;
            $display("FAIL R1 gates actual=%b%b expected=000000", hi_gate, lo_gate);
        end
        rst = 1'b0;
        tag = "R1"; run(2);

        enable = 1'b1;
        tag = "R2";
        hi_pwm = 3'b001; lo_pwm = 3'b000; run(12);
        hi_pwm = 3'b000; lo_pwm = 3'b001; run(12);
        hi_pwm = 3'b010; lo_pwm = 3'b100; run(12);
        hi_pwm = 3'b000; lo_pwm = 3'b000; run(4);

        tag = "R3";
        hi_pwm = 3'b011; lo_pwm = 3'b001; run(12);
        hi_pwm = 3'b101; lo_pwm = 3'b101; run(4);

        tag = "R4";
        hi_pwm = 3'b111; lo_pwm = 3'b101; run(12);
        lo_pwm = 3'b010; run(12);
        lo_pwm = 3'b000; run(12);

        tag = "R5";
        for (int c = 0; c < 8; c++) begin
            code = 3'(c);
            lo_pwm = ~lo_pwm; run(dead_of(code) + 3);
            lo_pwm = ~lo_pwm; run(dead_of(code) + 3);
        end
        code = 3'd3; run(10);

        tag = "R6";
        enable = 1'b0; run(3);
        enable = 1'b1; run(3);

        tag = "R7";
        vcmp = 1'b0; vfb = 1'b0; rfb = 1'b0;
        f_sov = 1'b1; run(2);
        f_sov = 1'b0; run(4);
        tag = "R10"; ack_pulse();

        tag = "R8";
        f_vds = 1'b1; vcmp = 1'b1; vfb = 1'b0; run(4);
        vcmp = 1'b0; vfb = 1'b1; run(4);
        vcmp = 1'b1; vfb = 1'b1; run(2);
        f_vds = 1'b0; run(3);
        ack_pulse();

        tag = "R9";
        f_rov = 1'b1; rfb = 1'b0; run(4);
        rfb = 1'b1; run(2);
        tag = "R10";
        ack = 1'b1; run(1); ack = 1'b0; run(3);
        f_rov = 1'b0; run(2);
        ack_pulse();
        hi_pwm = 3'b100; lo_pwm = 3'b011; run(12);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule